// File: doc/BRIEF.md
# Payload Packet ID Sequencer

This block frames outgoing payload packets on the user side of a card-to-host streaming DMA. A request carries a queue ID, a byte length, a completion-wanted flag, a marker flag and an immediate flag. For every payload request the block sends one or more beats on an AXI4-Stream style output bus. The beats carry the payload words taken from a separate data input. Sideband control fields go with the beats, and the last beat carries an empty-byte count.

Each payload packet gets a running 16-bit packet ID. The ID is exported with a one-cycle strobe so that the completion path can name the payload its completion waits for. Zero-length packets still take one beat. Marker packets are forced to one full-width beat that always wants a completion. Immediate (completion-only) requests are accepted with no beats and no ID.

Top module: `pld_pktid_framer`

## Requirements
- R1: After reset the first payload packet gets ID 1 and each later payload packet gets the previous ID plus one. `id_value` takes the new ID, and `id_strobe` is high for exactly one cycle, in the cycle after the request handshake. `o_pkt_id` carries the same ID on every beat of that packet.
- R2: The packet ID is 16 bits wide. After 16'hFFFF the next payload packet gets ID 0, and counting continues upward from there.
- R3: A payload packet of length L bytes, with B bytes per beat, takes ceil(L/B) beats. `o_last` is high on the final beat only.
- R4: `o_mty` equals (B - (L mod B)) mod B on the last beat and 0 on every other beat.
- R5: A request of length 0 gives exactly one beat, with `o_len` = 0, `o_mty` = 0 and `o_last` = 1.
- R6: A request with `req_marker` = 1 gives one beat with `o_len` = B, `o_mty` = 0, `o_marker` = 1 and `o_has_cmpt` = 1, whatever length and completion flag were requested.
- R7: For non-marker packets, `o_has_cmpt` copies `req_has_cmpt`. A value of 0 marks a payload-only packet.
- R8: A request with `req_imm` = 1 is accepted and produces no beat and no strobe, and it leaves `id_value` unchanged.
- R9: `o_qid`, `o_len`, `o_has_cmpt`, `o_marker` and `o_pkt_id` stay constant from the first beat through the last beat of a packet. They do not change while `o_valid` is high and `o_ready` is low.
- R10: `req_ready` is high when no packet is in flight, or in the cycle in which the last beat completes its handshake. `o_valid` is high exactly when a packet is in flight and `pld_valid` is high. `pld_ready` is high exactly when a packet is in flight and `o_ready` is high. `o_data` passes `pld_data` through.
- R11: During and right after reset, `o_valid`, `pld_ready` and `id_strobe` are 0, `req_ready` is 1 and `id_value` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Packet request valid |
| req_ready | output | 1 | Packet request accepted |
| req_imm | input | 1 | Completion-only request, no payload |
| req_marker | input | 1 | Marker packet request |
| req_has_cmpt | input | 1 | Packet wants a completion entry |
| req_qid | input | QID_W | Descriptor queue ID |
| req_len | input | LEN_W | Payload length in bytes |
| pld_valid | input | 1 | Payload word valid |
| pld_ready | output | 1 | Payload word consumed |
| pld_data | input | DATA_W | Payload word |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Output beat accepted |
| o_data | output | DATA_W | Output beat data |
| o_last | output | 1 | Final beat of packet |
| o_mty | output | MTY_W | Empty bytes in final beat |
| o_qid | output | QID_W | Queue ID of packet |
| o_len | output | LEN_W | Packet length in bytes |
| o_has_cmpt | output | 1 | Packet has a completion |
| o_marker | output | 1 | Packet is a marker |
| o_pkt_id | output | ID_W | Packet ID on the bus |
| id_strobe | output | 1 | New packet ID issued |
| id_value | output | ID_W | Most recently issued packet ID |

## Verification
Two functions can fall in the same cycle: the handshake of a packet's final beat and the acceptance of the next request. In that cycle the new ID is issued and the control fields are reloaded. The bench provokes this by holding `req_valid`, `pld_valid` and `o_ready` high over long runs of single-beat packets, including the run that carries the ID through its wrap. The reference model judges every cycle: it predicts `req_ready` from its own queue of pending beats, and it checks that the next packet's first beat follows at once with the incremented ID and its own fields.

// File: rtl/pld_pktid_pkg.sv
package pld_pktid_pkg;
  typedef enum logic [0:0] {
    FR_IDLE = 1'b0,
    FR_BEAT = 1'b1
  } frame_state_e;
endpackage

// File: rtl/pld_id_counter.sv
module pld_id_counter #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  output logic [ID_W-1:0] id_next,
  output logic [ID_W-1:0] id_value,
  output logic            id_strobe
);
  logic [ID_W-1:0] cnt_q, cnt_d;
  logic            stb_q, stb_d;
  logic            cnt_en;

  assign id_next = cnt_q + ID_W'(1);
  assign cnt_en  = advance;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = id_next;
    stb_d = advance;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign id_value  = cnt_q;
  assign id_strobe = stb_q;
endmodule

// File: rtl/pld_beat_plan.sv
module pld_beat_plan #(
  parameter int LEN_W   = 16,
  parameter int BPB_LOG = 6,
  localparam int BPB    = 1 << BPB_LOG,
  localparam int MTY_W  = (BPB_LOG > 0) ? BPB_LOG : 1,
  localparam int BEAT_W = LEN_W + 1
) (
  input  logic [LEN_W-1:0]  len,
  input  logic              marker,
  input  logic              has_cmpt,
  output logic [LEN_W-1:0]  eff_len,
  output logic              eff_has_cmpt,
  output logic [BEAT_W-1:0] beats,
  output logic [MTY_W-1:0]  last_mty
);
  logic [LEN_W-1:0] tail_bytes;
  logic [LEN_W-1:0] empty_bytes;
  logic [BEAT_W-1:0] raw_beats;

  assign eff_len      = marker ? LEN_W'(BPB) : len;
  assign eff_has_cmpt = marker | has_cmpt;

  // empty bytes = (BPB - len mod BPB) mod BPB
  assign tail_bytes  = eff_len & LEN_W'(BPB - 1);
  assign empty_bytes = (LEN_W'(BPB) - tail_bytes) & LEN_W'(BPB - 1);
  assign last_mty    = MTY_W'(empty_bytes);

  generate
    if (BPB_LOG == 0) begin : g_byte_bus
      assign raw_beats = {1'b0, eff_len};
    end else begin : g_wide_bus
      logic [BEAT_W-1:0] padded;
      assign padded    = {1'b0, eff_len} + BEAT_W'(BPB - 1);
      assign raw_beats = padded >> BPB_LOG;
    end
  endgenerate

  assign beats = (eff_len == '0) ? BEAT_W'(1) : raw_beats;
endmodule

// File: rtl/pld_frame_ctrl.sv
module pld_frame_ctrl
  import pld_pktid_pkg::*;
#(
  parameter int DATA_W = 512,
  parameter int LEN_W  = 16,
  parameter int QID_W  = 11,
  parameter int ID_W   = 16,
  parameter int MTY_W  = 6,
  localparam int BEAT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_imm,
  input  logic [QID_W-1:0]  req_qid,
  input  logic [LEN_W-1:0]  plan_len,
  input  logic              plan_has_cmpt,
  input  logic              req_marker,
  input  logic [BEAT_W-1:0] plan_beats,
  input  logic [MTY_W-1:0]  plan_mty,
  input  logic [ID_W-1:0]   id_next,
  output logic              pay_accept,
  input  logic              pld_valid,
  output logic              pld_ready,
  input  logic [DATA_W-1:0] pld_data,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [DATA_W-1:0] o_data,
  output logic              o_last,
  output logic [MTY_W-1:0]  o_mty,
  output logic [QID_W-1:0]  o_qid,
  output logic [LEN_W-1:0]  o_len,
  output logic              o_has_cmpt,
  output logic              o_marker,
  output logic [ID_W-1:0]   o_pkt_id
);
  frame_state_e      state_q, state_d;
  logic [BEAT_W-1:0] rem_q, rem_d;
  logic [QID_W-1:0]  qid_q, qid_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              hc_q, hc_d;
  logic              mk_q, mk_d;
  logic [MTY_W-1:0]  mty_q, mty_d;
  logic [ID_W-1:0]   pid_q, pid_d;

  logic active, final_beat, beat_fire, req_fire;
  logic load_en, step_en;

  assign active     = (state_q == FR_BEAT);
  assign final_beat = active && (rem_q == BEAT_W'(1));
  assign o_valid    = active & pld_valid;
  assign pld_ready  = active & o_ready;
  assign beat_fire  = o_valid & o_ready;
  assign req_ready  = !active || (beat_fire && final_beat);
  assign req_fire   = req_valid & req_ready;
  assign pay_accept = req_fire & !req_imm;

  assign load_en = pay_accept;
  assign step_en = beat_fire & !pay_accept;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    qid_d   = qid_q;
    len_d   = len_q;
    hc_d    = hc_q;
    mk_d    = mk_q;
    mty_d   = mty_q;
    pid_d   = pid_q;
    if (load_en) begin
      state_d = FR_BEAT;
      rem_d   = plan_beats;
      qid_d   = req_qid;
      len_d   = plan_len;
      hc_d    = plan_has_cmpt;
      mk_d    = req_marker;
      mty_d   = plan_mty;
      pid_d   = id_next;
    end else if (step_en) begin
      rem_d = rem_q - BEAT_W'(1);
      if (final_beat) state_d = FR_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      rem_q   <= '0;
      qid_q   <= '0;
      len_q   <= '0;
      hc_q    <= 1'b0;
      mk_q    <= 1'b0;
      mty_q   <= '0;
      pid_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      qid_q   <= qid_d;
      len_q   <= len_d;
      hc_q    <= hc_d;
      mk_q    <= mk_d;
      mty_q   <= mty_d;
      pid_q   <= pid_d;
    end
  end

  assign o_data     = pld_data;
  assign o_last     = final_beat;
  assign o_mty      = final_beat ? mty_q : '0;
  assign o_qid      = qid_q;
  assign o_len      = len_q;
  assign o_has_cmpt = hc_q;
  assign o_marker   = mk_q;
  assign o_pkt_id   = pid_q;
endmodule

// File: rtl/pld_pktid_framer.sv
module pld_pktid_framer #(
  parameter int DATA_W = 512,
  parameter int LEN_W  = 16,
  parameter int QID_W  = 11,
  parameter int ID_W   = 16,
  localparam int BPB_LOG = $clog2(DATA_W / 8),
  localparam int MTY_W   = (BPB_LOG > 0) ? BPB_LOG : 1,
  localparam int BEAT_W  = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_imm,
  input  logic              req_marker,
  input  logic              req_has_cmpt,
  input  logic [QID_W-1:0]  req_qid,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              pld_valid,
  output logic              pld_ready,
  input  logic [DATA_W-1:0] pld_data,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [DATA_W-1:0] o_data,
  output logic              o_last,
  output logic [MTY_W-1:0]  o_mty,
  output logic [QID_W-1:0]  o_qid,
  output logic [LEN_W-1:0]  o_len,
  output logic              o_has_cmpt,
  output logic              o_marker,
  output logic [ID_W-1:0]   o_pkt_id,
  output logic              id_strobe,
  output logic [ID_W-1:0]   id_value
);
  logic [LEN_W-1:0]  plan_len;
  logic              plan_hc;
  logic [BEAT_W-1:0] plan_beats;
  logic [MTY_W-1:0]  plan_mty;
  logic [ID_W-1:0]   id_next;
  logic              pay_accept;

  pld_beat_plan #(.LEN_W(LEN_W), .BPB_LOG(BPB_LOG)) u_plan (
    .len(req_len), .marker(req_marker), .has_cmpt(req_has_cmpt),
    .eff_len(plan_len), .eff_has_cmpt(plan_hc),
    .beats(plan_beats), .last_mty(plan_mty)
  );

  pld_id_counter #(.ID_W(ID_W)) u_ids (
    .clk(clk), .rst_n(rst_n), .advance(pay_accept),
    .id_next(id_next), .id_value(id_value), .id_strobe(id_strobe)
  );

  pld_frame_ctrl #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .QID_W(QID_W), .ID_W(ID_W), .MTY_W(MTY_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_imm(req_imm),
    .req_qid(req_qid), .plan_len(plan_len), .plan_has_cmpt(plan_hc),
    .req_marker(req_marker), .plan_beats(plan_beats), .plan_mty(plan_mty),
    .id_next(id_next), .pay_accept(pay_accept),
    .pld_valid(pld_valid), .pld_ready(pld_ready), .pld_data(pld_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_last(o_last),
    .o_mty(o_mty), .o_qid(o_qid), .o_len(o_len), .o_has_cmpt(o_has_cmpt),
    .o_marker(o_marker), .o_pkt_id(o_pkt_id)
  );
endmodule

// File: rtl/pld_pktid_framer_chk.sv
module pld_pktid_framer_chk #(
  parameter int LEN_W = 16,
  parameter int QID_W = 11,
  parameter int ID_W  = 16,
  parameter int MTY_W = 6,
  parameter int BPB   = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_imm,
  input logic             o_valid,
  input logic             o_ready,
  input logic             o_last,
  input logic [MTY_W-1:0] o_mty,
  input logic [QID_W-1:0] o_qid,
  input logic [LEN_W-1:0] o_len,
  input logic             o_has_cmpt,
  input logic             o_marker,
  input logic [ID_W-1:0]  o_pkt_id,
  input logic             id_strobe,
  input logic [ID_W-1:0]  id_value
);
  assert_id_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    id_strobe |-> id_value == $past(id_value) + ID_W'(1));

  assert_id_only_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (id_value != $past(id_value)) |-> id_strobe);

  assert_mid_beat_no_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_last) |-> (o_mty == '0));

  assert_zero_len_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_len == '0) |-> (o_last && o_mty == '0));

  assert_marker_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_marker) |-> (o_last && o_mty == '0 && o_has_cmpt && o_len == LEN_W'(BPB)));

  assert_imm_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_imm) |=> !id_strobe);

  assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> ($stable(o_qid) && $stable(o_len) && $stable(o_has_cmpt)
                               && $stable(o_marker) && $stable(o_pkt_id)));

  assert_no_accept_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_last) |-> !req_ready);
endmodule

bind pld_pktid_framer pld_pktid_framer_chk #(
  .LEN_W(LEN_W), .QID_W(QID_W), .ID_W(ID_W), .MTY_W(MTY_W), .BPB(1 << BPB_LOG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_imm(req_imm), .o_valid(o_valid), .o_ready(o_ready), .o_last(o_last),
  .o_mty(o_mty), .o_qid(o_qid), .o_len(o_len), .o_has_cmpt(o_has_cmpt),
  .o_marker(o_marker), .o_pkt_id(o_pkt_id), .id_strobe(id_strobe),
  .id_value(id_value)
);

// File: tb/pld_pktid_framer_tb.sv
module pld_pktid_framer_tb;
  localparam int DATA_W = 64;
  localparam int LEN_W  = 16;
  localparam int QID_W  = 11;
  localparam int ID_W   = 16;
  localparam int BPB    = DATA_W / 8;
  localparam int MTY_W  = 3;

  logic clk, rst_n;
  logic req_valid, req_ready, req_imm, req_marker, req_has_cmpt;
  logic [QID_W-1:0] req_qid;
  logic [LEN_W-1:0] req_len;
  logic pld_valid, pld_ready;
  logic [DATA_W-1:0] pld_data, o_data;
  logic o_valid, o_ready, o_last, o_has_cmpt, o_marker, id_strobe;
  logic [MTY_W-1:0] o_mty;
  logic [QID_W-1:0] o_qid;
  logic [LEN_W-1:0] o_len;
  logic [ID_W-1:0] o_pkt_id, id_value;

  pld_pktid_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W), .QID_W(QID_W), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_imm(req_imm), .req_marker(req_marker), .req_has_cmpt(req_has_cmpt),
    .req_qid(req_qid), .req_len(req_len), .pld_valid(pld_valid),
    .pld_ready(pld_ready), .pld_data(pld_data), .o_valid(o_valid),
    .o_ready(o_ready), .o_data(o_data), .o_last(o_last), .o_mty(o_mty),
    .o_qid(o_qid), .o_len(o_len), .o_has_cmpt(o_has_cmpt), .o_marker(o_marker),
    .o_pkt_id(o_pkt_id), .id_strobe(id_strobe), .id_value(id_value)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int qid; int len; bit hc; bit mk; bit last; int mty; int pid;
  } beat_t;
  beat_t q[$];

  int  n_chk = 0, n_bad = 0;
  int  exp_id = 0;
  bit  strobe_pend = 0;
  bit  monitor_on = 0;
  bit  fast = 0;
  bit  wrapped = 0;
  bit  saw_zero_id = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void push_pkt(int qid, int len, bit hc, bit mk, int pid);
    int eff, nb, mty;
    eff = mk ? BPB : len;
    nb  = mk ? 1 : ((len == 0) ? 1 : (len + BPB - 1) / BPB);
    mty = (BPB - (eff % BPB)) % BPB;
    for (int i = 0; i < nb; i++) begin
      beat_t b;
      b.qid = qid; b.len = eff; b.hc = mk ? 1'b1 : hc; b.mk = mk;
      b.last = (i == nb - 1); b.mty = b.last ? mty : 0; b.pid = pid;
      q.push_back(b);
    end
  endfunction

  // reference model, compared on every clock away from the active edge
  always @(negedge clk) begin
    if (rst_n && monitor_on && !finished) begin
      bit fire_o, exp_rr;
      chk(id_strobe == strobe_pend, wrapped ? "R2 strobe" : "R1 strobe", id_strobe, strobe_pend);
      chk(id_value == ID_W'(exp_id), wrapped ? "R2 id_value" : "R1 id_value", id_value, exp_id);
      if (id_strobe && id_value == 0) saw_zero_id = 1;
      chk(o_valid == (q.size() > 0 && pld_valid), "R10 o_valid", o_valid, q.size() > 0 && pld_valid);
      chk(pld_ready == (q.size() > 0 && o_ready), "R10 pld_ready", pld_ready, q.size() > 0 && o_ready);
      fire_o = o_valid && o_ready;
      if (o_valid && q.size() > 0) begin
        beat_t e;
        e = q[0];
        chk(o_data == pld_data, "R10 o_data", o_data, pld_data);
        chk(o_last == e.last, "R3 o_last", o_last, e.last);
        chk(o_mty == MTY_W'(e.mty), (e.len == 0) ? "R5 o_mty" : "R4 o_mty", o_mty, e.mty);
        chk(o_len == LEN_W'(e.len), e.mk ? "R6 o_len" : "R9 o_len", o_len, e.len);
        chk(o_marker == e.mk, "R6 o_marker", o_marker, e.mk);
        chk(o_has_cmpt == e.hc, e.mk ? "R6 o_has_cmpt" : "R7 o_has_cmpt", o_has_cmpt, e.hc);
        chk(o_qid == QID_W'(e.qid), "R9 o_qid", o_qid, e.qid);
        chk(o_pkt_id == ID_W'(e.pid), "R1 o_pkt_id", o_pkt_id, e.pid);
      end
      exp_rr = (q.size() == 0) || (q.size() == 1 && fire_o);
      chk(req_ready == exp_rr, "R10 req_ready", req_ready, exp_rr);
      if (fire_o && q.size() > 0) void'(q.pop_front());
      strobe_pend = 0;
      if (req_valid && req_ready && !req_imm) begin
        exp_id = (exp_id + 1) & 16'hFFFF;
        if (exp_id == 0) wrapped = 1;
        push_pkt(req_qid, req_len, req_has_cmpt, req_marker, exp_id);
        strobe_pend = 1;
      end
    end
  end

  // output back-pressure and payload supply
  initial begin
    o_ready = 1'b0; pld_valid = 1'b0; pld_data = '0;
    forever begin
      @(posedge clk); #1;
      if (fast) begin
        o_ready = 1'b1; pld_valid = 1'b1;
      end else begin
        o_ready   = ($urandom % 4) != 0;
        pld_valid = ($urandom % 4) != 0;
      end
      pld_data = {$urandom, $urandom};
    end
  end

  task automatic send(input int qid, input int len, input bit hc, input bit mk, input bit imm);
    bit fired;
    req_valid = 1'b1; req_qid = QID_W'(qid); req_len = LEN_W'(len);
    req_has_cmpt = hc; req_marker = mk; req_imm = imm;
    do begin
      @(negedge clk); fired = req_ready;
      @(posedge clk); #1;
    end while (!fired);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() > 0 && guard < 2000) begin
      @(posedge clk); #1; guard++;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    req_valid = 1'b0; req_imm = 1'b0; req_marker = 1'b0; req_has_cmpt = 1'b0;
    req_qid = '0; req_len = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(o_valid == 0, "R11 o_valid", o_valid, 0);
    chk(pld_ready == 0, "R11 pld_ready", pld_ready, 0);
    chk(id_strobe == 0, "R11 id_strobe", id_strobe, 0);
    chk(req_ready == 1, "R11 req_ready", req_ready, 1);
    chk(id_value == 0, "R11 id_value", id_value, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    monitor_on = 1;
    @(negedge clk);
    chk(id_value == 0 && o_valid == 0, "R11 after release", id_value, 0);
    @(posedge clk); #1;
    // R3/R4 multi-beat lengths, R7 completion flag
    send(5, 1, 1, 0, 0);
    send(6, 8, 1, 0, 0);
    send(7, 9, 0, 0, 0);
    send(8, 17, 1, 0, 0);
    send(9, 64, 0, 0, 0);
    send(10, 23, 1, 0, 0);
    drain();
    // R5 zero length, R6 marker overriding length and flag
    send(11, 0, 1, 0, 0);
    send(12, 3, 0, 1, 0);
    send(13, 0, 0, 0, 0);
    drain();
    // R8 immediate requests between payload packets
    send(14, 40, 1, 0, 1);
    send(15, 0, 0, 1, 1);
    drain();
    chk(id_value == ID_W'(exp_id), "R8 id after immediate", id_value, exp_id);
    send(16, 12, 1, 0, 0);
    send(17, 5, 1, 0, 1);
    send(18, 31, 0, 0, 0);
    drain();
    // R10 back-to-back acceptance on the last beat, R2 wrap of the ID
    fast = 1;
    @(posedge clk); #1;
    for (int i = 0; i < 65540; i++) begin
      send(i % 2048, 1 + (i % BPB), i % 2, 0, 0);
    end
    drain();
    chk(saw_zero_id == 1, "R2 id 0 issued after wrap", saw_zero_id, 1);
    chk(wrapped == 1, "R2 wrap reached", wrapped, 1);
    send(19, 2, 1, 0, 0);
    drain();
    chk(id_value == ID_W'(exp_id), "R2 counting on after wrap", id_value, exp_id);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule